// File: doc/BRIEF.md
# Post-Configuration Startup Sequencer

After a device has taken in its configuration data, five chip-wide controls must be released in a chosen order: the DONE indication, the output-buffer enable, the release of global set/reset, the release of write enable for storage elements, and the release of the clock-recovery loop (DLL). This block works in one system clock domain. It advances a phase counter on single-cycle enable pulses that mark rising edges of the startup clock, and it releases each control when the counter reaches the phase chosen for it in a static settings word.

The startup clock is selected from three sources: the configuration clock, a user clock or the JTAG clock. Besides a phase number, an event can be tied to the moment the sensed done line goes high, held at its level from that moment ("keep"), or, for the DLL only, released at phase zero or with no wait at all. DONE behaves like an open-drain line. The sequencer will not move past the DONE phase until the sensed done input reads high. That input can optionally be delayed by one clock. A setting that is not allowed for the chosen source falls back to releasing with DONE, and a status flag reports it.

Top module: `startup_seq`

## Requirements
- R1: After reset, and while the sequencer is idle, all five event outputs are low. The one exception is a DLL event coded no-wait, which follows `lc_met_i`. The sequencer leaves idle on the first clock on which `lc_met_i` is high. At that point the phase counter is 0.
- R2: `clk_src_i` selects the startup edge. 0 and 3 select `cclk_en_i`, 2 selects `jclk_en_i`, and 1 selects the user clock. In user mode, phase 0 advances to 1 on `cclk_en_i` and every later phase advances on `uclk_en_i`. Pulses on unselected enables have no effect.
- R3: Each event takes a 4-bit code from `ev_cfg_i`, with event k at bits [4k+3:4k]. The event order is done, output enable, set/reset, write enable, DLL. A code n from 0 to 7 asserts the event, combinationally, once the phase counter reaches n. The counter advances by one per qualifying edge and stops at 7.
- R4: While the counter equals the DONE phase, it does not advance until the sensed done input is high.
- R5: With `done_pipe_i`=1, the sensed done is `done_in_i` delayed by one clock. With `done_pipe_i`=0, it is `done_in_i` itself.
- R6: Code 8 asserts the event one clock after the sensed done is first sampled high while the sequencer is not idle.
- R7: Code 9 (keep) never asserts the event.
- R8: Code 10 (no wait) asserts the DLL event in the same cycle that `lc_met_i` is high, even while idle, and holds it from then on.
- R9: The valid codes depend on the mode.
  - Non-user modes: DONE may be 1–7; output enable, set/reset and write enable may be 1–6, 8 or 9; DLL may be 0–6 or 10.
  - User mode: DONE may be 1–3; output enable and set/reset may be 2–4; write enable and DLL have no valid code.
  - An invalid code releases its event together with DONE and raises `cfg_bad_o`. An invalid DONE code uses phase 3.
- R10: Once every event is either asserted or coded keep, the sequencer is terminal. From then until reset, no input changes any output.
- R11: An asserted event output stays asserted until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lc_met_i | input | 1 | Length count reached, level |
| cclk_en_i | input | 1 | Configuration clock rising-edge pulse |
| uclk_en_i | input | 1 | User clock rising-edge pulse |
| jclk_en_i | input | 1 | JTAG clock rising-edge pulse |
| clk_src_i | input | 2 | Startup clock source select |
| done_pipe_i | input | 1 | Delay the sensed done by one clock |
| done_in_i | input | 1 | External done line sense |
| ev_cfg_i | input | 20 | Five 4-bit event codes |
| done_o | output | 1 | DONE drive, high releases the line |
| out_en_o | output | 1 | Output enable release |
| sr_rel_o | output | 1 | Global set/reset release |
| we_rel_o | output | 1 | Write enable release |
| dll_rel_o | output | 1 | DLL release |
| cfg_bad_o | output | 1 | Setting invalid for selected source |

## Verification
A phase counter that steps on the wrong enable, or steps twice, moves an event output by at least one cycle. The per-cycle reference comparison catches this on the first edge where the two counts differ. A broken done stall shows up while the external done is held low: events coded for a later phase assert early, in the very cycle after the counter should have held. If the terminal state or an event latch is not sticky, some output drops once done is released again. The monotonic check and the post-terminal stability window report this at once.

// File: rtl/startup_pkg.sv
package startup_pkg;
  localparam int NUM_EV = 5;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_ON_DONE = 4'd8;
  localparam logic [CODE_W-1:0] CODE_KEEP    = 4'd9;
  localparam logic [CODE_W-1:0] CODE_NO_WAIT = 4'd10;
  localparam int DONE_FALLBACK = 3;

  localparam int EV_DONE = 0;
  localparam int EV_OE   = 1;
  localparam int EV_SR   = 2;
  localparam int EV_WE   = 3;
  localparam int EV_DLL  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_END} seq_st_e;

  function automatic logic code_ok(input int idx, input logic [CODE_W-1:0] c, input logic usr);
    logic ok;
    ok = 1'b0;
    if (usr) begin
      case (idx)
        EV_DONE:      ok = (c >= 4'd1) && (c <= 4'd3);
        EV_OE, EV_SR: ok = (c >= 4'd2) && (c <= 4'd4);
        default:      ok = 1'b0;
      endcase
    end else begin
      case (idx)
        EV_DONE:             ok = (c >= 4'd1) && (c <= 4'd7);
        EV_OE, EV_SR, EV_WE: ok = ((c >= 4'd1) && (c <= 4'd6)) || c == CODE_ON_DONE || c == CODE_KEEP;
        EV_DLL:              ok = (c <= 4'd6) || c == CODE_NO_WAIT;
        default:             ok = 1'b0;
      endcase
    end
    return ok;
  endfunction
endpackage

// File: rtl/startup_phase_ctr.sv
module startup_phase_ctr
  import startup_pkg::*;
#(
  parameter int PH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lc_met_i,
  input  logic            adv_i,
  input  logic            done_ok_i,
  input  logic [PH_W-1:0] done_ph_i,
  input  logic            all_fired_i,
  output logic            active_o,
  output logic            term_o,
  output logic [PH_W-1:0] ph_o
);
  localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};

  seq_st_e         st_q;
  logic [PH_W-1:0] ph_q;
  logic            hold;

  assign hold = (ph_q == done_ph_i) && !done_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (lc_met_i) begin
          st_q <= ST_RUN;
          ph_q <= '0;
        end
        ST_RUN: begin
          if (all_fired_i) st_q <= ST_END;
          else if (adv_i && !hold && ph_q != PH_MAX) ph_q <= ph_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign active_o = (st_q != ST_IDLE);
  assign term_o   = (st_q == ST_END);
  assign ph_o     = ph_q;

  // R3
  ph_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> (ph_q == $past(ph_q) || ph_q == $past(ph_q) + 1'b1));

  // R4
  done_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && hold) |=> $stable(ph_q));

  // R10
  term_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> (term_o && $stable(ph_q)));
endmodule

// File: rtl/startup_event_dec.sv
module startup_event_dec
  import startup_pkg::*;
#(
  parameter int PH_W = 3,
  parameter int IDX  = 0
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              usr_i,
  input  logic [PH_W-1:0]   ph_i,
  input  logic              active_i,
  input  logic              done_rel_i,
  input  logic              done_seen_i,
  input  logic              lc_met_i,
  output logic              fire_o,
  output logic              settled_o,
  output logic              bad_o
);
  logic ok;

  always_comb begin
    ok    = code_ok(IDX, code_i, usr_i);
    bad_o = !ok;
    if (!ok) fire_o = done_rel_i;
    else begin
      case (code_i)
        CODE_ON_DONE: fire_o = done_seen_i;
        CODE_KEEP:    fire_o = 1'b0;
        CODE_NO_WAIT: fire_o = lc_met_i || active_i;
        default:      fire_o = active_i && (32'(ph_i) >= 32'(code_i));
      endcase
    end
    settled_o = fire_o || (ok && code_i == CODE_KEEP);
  end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int PH_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lc_met_i,
  input  logic                     cclk_en_i,
  input  logic                     uclk_en_i,
  input  logic                     jclk_en_i,
  input  logic [1:0]               clk_src_i,
  input  logic                     done_pipe_i,
  input  logic                     done_in_i,
  input  logic [NUM_EV*CODE_W-1:0] ev_cfg_i,
  output logic                     done_o,
  output logic                     out_en_o,
  output logic                     sr_rel_o,
  output logic                     we_rel_o,
  output logic                     dll_rel_o,
  output logic                     cfg_bad_o
);
  logic              usr, sclk_en, adv;
  logic              done_q, done_ok, done_seen_q;
  logic              active, term;
  logic [PH_W-1:0]   ph, done_ph;
  logic              done_rel, all_fired;
  logic [CODE_W-1:0] code [NUM_EV];
  logic [NUM_EV-1:0] fire, settled, bad;

  assign usr = (clk_src_i == 2'd1);

  always_comb begin
    case (clk_src_i)
      2'd1:    sclk_en = uclk_en_i;
      2'd2:    sclk_en = jclk_en_i;
      default: sclk_en = cclk_en_i;
    endcase
  end

  // user mode: first phase still on the configuration clock
  assign adv = (usr && ph == '0) ? cclk_en_i : sclk_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      done_seen_q <= 1'b0;
    end else begin
      done_q <= done_in_i;
      if (active && done_ok) done_seen_q <= 1'b1;
    end
  end

  assign done_ok  = done_pipe_i ? done_q : done_in_i;
  assign done_ph  = code_ok(EV_DONE, code[EV_DONE], usr) ? code[EV_DONE][PH_W-1:0]
                                                          : PH_W'(DONE_FALLBACK);
  assign done_rel = active && (ph >= done_ph);

  startup_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lc_met_i   (lc_met_i),
    .adv_i      (adv),
    .done_ok_i  (done_ok),
    .done_ph_i  (done_ph),
    .all_fired_i(all_fired),
    .active_o   (active),
    .term_o     (term),
    .ph_o       (ph)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    assign code[g] = ev_cfg_i[g*CODE_W +: CODE_W];
    startup_event_dec #(.PH_W(PH_W), .IDX(g)) u_dec (
      .code_i     (code[g]),
      .usr_i      (usr),
      .ph_i       (ph),
      .active_i   (active),
      .done_rel_i (done_rel),
      .done_seen_i(done_seen_q),
      .lc_met_i   (lc_met_i),
      .fire_o     (fire[g]),
      .settled_o  (settled[g]),
      .bad_o      (bad[g])
    );
  end

  assign all_fired = &settled;
  assign done_o    = fire[EV_DONE];
  assign out_en_o  = fire[EV_OE];
  assign sr_rel_o  = fire[EV_SR];
  assign we_rel_o  = fire[EV_WE];
  assign dll_rel_o = fire[EV_DLL];
  assign cfg_bad_o = |bad;

  // R11
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !lc_met_i) |-> !(done_o || out_en_o || sr_rel_o || we_rel_o || dll_rel_o));

  // R6
  seen_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_seen_q) |-> $past(done_ok && active));

  // R10
  term_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term |=> $stable(fire));
endmodule

// File: tb/startup_seq_tb_top.sv
`timescale 1ns/1ps
module startup_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lc_met_i = 1'b0, cclk_en_i = 1'b0, uclk_en_i = 1'b0, jclk_en_i = 1'b0;
  logic [1:0]  clk_src_i = 2'd0;
  logic        done_pipe_i = 1'b0, done_in_i;
  logic [19:0] ev_cfg_i = '0;
  logic        done_o, out_en_o, sr_rel_o, we_rel_o, dll_rel_o, cfg_bad_o;
  logic        ext_hold = 1'b0;

  always #2.5 clk_i = ~clk_i;
  assign done_in_i = done_o & ~ext_hold;

  startup_seq dut_i (.*);

  int total = 0, bad = 0;
  bit fin = 1'b0;
  int cnt, lc_at, hold_lo, hold_hi;
  bit m_act, m_term, m_seen, m_pipe;
  int m_ph;
  logic [4:0] prev_ev;

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code_of(int i);
    return int'(ev_cfg_i[i*4 +: 4]);
  endfunction

  function automatic bit m_ok(int i, int c, bit usr);
    if (usr) begin
      if (i == 0) return c >= 1 && c <= 3;
      if (i == 1 || i == 2) return c >= 2 && c <= 4;
      return 0;
    end
    if (i == 0) return c >= 1 && c <= 7;
    if (i == 4) return c <= 6 || c == 10;
    return (c >= 1 && c <= 6) || c == 8 || c == 9;
  endfunction

  function automatic int m_dph();
    bit usr = (clk_src_i == 2'd1);
    return m_ok(0, code_of(0), usr) ? code_of(0) : 3;
  endfunction

  function automatic bit m_fire(int i, bit lc);
    bit usr = (clk_src_i == 2'd1);
    int c = code_of(i);
    bit drel = m_act && m_ph >= m_dph();
    if (!m_ok(i, c, usr)) return drel;
    if (c == 8) return m_seen;
    if (c == 9) return 0;
    if (c == 10) return lc || m_act;
    return m_act && m_ph >= c;
  endfunction

  task automatic do_reset(logic [1:0] src, bit pipe, logic [19:0] cfg);
    rst_ni = 1'b0;
    clk_src_i = src; done_pipe_i = pipe; ev_cfg_i = cfg;
    lc_met_i = 0; ext_hold = 0; cclk_en_i = 0; uclk_en_i = 0; jclk_en_i = 0;
    m_act = 0; m_term = 0; m_seen = 0; m_pipe = 0; m_ph = 0; prev_ev = '0; cnt = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 done", done_o, 0); chk("R1 oe", out_en_o, 0); chk("R1 sr", sr_rel_o, 0);
    chk("R1 we", we_rel_o, 0); chk("R1 dll", dll_rel_o, 0);
  endtask

  task automatic cyc(bit c, bit u, bit j);
    bit lv, dv, adv, sense, allf;
    logic [4:0] now, exp;
    int dph;
    cclk_en_i = c; uclk_en_i = u; jclk_en_i = j;
    lc_met_i = (cnt >= lc_at);
    ext_hold = (cnt >= hold_lo && cnt < hold_hi);
    #1;
    lv = lc_met_i; dv = done_in_i;
    now = {dll_rel_o, we_rel_o, sr_rel_o, out_en_o, done_o};
    allf = 1;
    for (int i = 0; i < 5; i++) begin
      exp[i] = m_fire(i, lv);
      if (!(exp[i] || (m_ok(i, code_of(i), clk_src_i == 2'd1) && code_of(i) == 9))) allf = 0;
    end
    chk("R4 R5 done", now[0], exp[0]);
    chk("R3 R6 oe", now[1], exp[1]);
    chk("R3 R7 sr", now[2], exp[2]);
    chk("R3 R9 we", now[3], exp[3]);
    chk("R8 dll", now[4], exp[4]);
    begin
      bit eb = 0;
      for (int i = 0; i < 5; i++) if (!m_ok(i, code_of(i), clk_src_i == 2'd1)) eb = 1;
      chk("R9 bad", cfg_bad_o, eb);
    end
    // R11 no released event falls back
    chk("R11 sticky", |(prev_ev & ~now), 1'b0);
    prev_ev = now;
    case (clk_src_i)
      2'd1: adv = (m_ph == 0) ? c : u;
      2'd2: adv = j;
      default: adv = c;
    endcase
    sense = done_pipe_i ? m_pipe : dv;
    dph = m_dph();
    @(posedge clk_i);
    if (!m_act) begin
      if (lv) begin m_act = 1; m_ph = 0; end
    end else begin
      if (sense) m_seen = 1;
      if (!m_term) begin
        if (allf) m_term = 1;
        else if (adv && !(m_ph == dph && !sense) && m_ph < 7) m_ph++;
      end
    end
    m_pipe = dv;
    cnt++;
    @(negedge clk_i);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc(($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0);
  endtask

  // R10 outputs frozen after the terminal state, even with done line dropped
  task automatic post_term();
    logic [4:0] snap;
    if (m_term) begin
      snap = {dll_rel_o, we_rel_o, sr_rel_o, out_en_o, done_o};
      hold_lo = cnt; hold_hi = cnt + 1000;
      run(20);
      chk("R10 frozen", ({dll_rel_o, we_rel_o, sr_rel_o, out_en_o, done_o} == snap), 1'b1);
    end
  endtask

  initial begin
    // S1 configuration clock, ordered phases
    do_reset(2'd0, 1'b0, {4'd2, 4'd6, 4'd5, 4'd5, 4'd4});
    lc_at = 3; hold_lo = 10; hold_hi = 60;
    run(150);
    chk("R3 all released", &{done_o, out_en_o, sr_rel_o, we_rel_o, dll_rel_o}, 1'b1);
    post_term();

    // S2 JTAG clock with pipe, on-done and keep codes
    do_reset(2'd2, 1'b1, {4'd0, 4'd1, 4'd9, 4'd8, 4'd7});
    lc_at = 1; hold_lo = 30; hold_hi = 90;
    for (int k = 0; k < 12; k++) cyc(1'b1, 1'b1, 1'b0);
    chk("R2 jtag ignores others", we_rel_o, 1'b0);
    chk("R8 dll at phase 0", dll_rel_o, 1'b1);
    run(200);
    chk("R7 keep stays low", sr_rel_o, 1'b0);
    chk("R6 on-done released", out_en_o, 1'b1);
    post_term();

    // S3 user clock, invalid write-enable and DLL codes
    do_reset(2'd1, 1'b0, {4'd10, 4'd3, 4'd4, 4'd2, 4'd1});
    lc_at = 2; hold_lo = 5; hold_hi = 40;
    run(150);
    chk("R9 flag", cfg_bad_o, 1'b1);
    chk("R9 we with done", we_rel_o, done_o);
    chk("R9 dll with done", dll_rel_o, done_o);
    post_term();

    // S4 invalid DONE code, no-wait DLL
    do_reset(2'd0, 1'b0, {4'd10, 4'd8, 4'd0, 4'd7, 4'd9});
    lc_met_i = 1'b1;
    #0.5;
    chk("R8 no wait while idle", dll_rel_o, 1'b1);
    chk("R1 done idle", done_o, 1'b0);
    lc_at = 0; hold_lo = 0; hold_hi = 25;
    run(150);
    post_term();

    // S5 source code 3 behaves as configuration clock, pipe on
    do_reset(2'd3, 1'b1, {4'd0, 4'd1, 4'd1, 4'd1, 4'd1});
    lc_at = 4; hold_lo = 0; hold_hi = 50;
    for (int k = 0; k < 12; k++) cyc(1'b0, 1'b1, 1'b1);
    chk("R2 code 3 ignores user/jtag", done_o, 1'b0);
    run(120);
    post_term();

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule